// File: doc/BRIEF.md
# Four-Phase Vertical Line-Shift Sequencer

This block generates the vertical transfer clocks of a frame-transfer image sensor during the blanking part of each horizontal line. A free-running horizontal phase counter, kept elsewhere, is fed in on every clock. The block compares that count against a fixed table of edge positions. From the comparisons it drives four image-section clock levels, four storage-section clock levels, a sample-and-clamp window and a substrate charge-reset strobe.

A line shift moves charge by exactly one line. The four phases are inverted from their resting levels in overlapping windows whose edges are staggered 20 counts apart. Image and storage phases of the same index move together. The higher-level frame controller decides which lines shift and which lines carry a charge reset. It does so by raising the shift or reset request, which the block samples once, at the arming count at the start of the line.

Top module: `vshift_seq`

## Requirements
- R1: While reset is high, and on the first clock after it falls, `img_clk` and `stg_clk` equal the resting pattern of R9, and `ssc` and `cr` are 0.
- R2: `ssc` is 1 exactly for phase counts 49 up to and including 348, on every line, whatever the requests are.
- R3: `cr` is 1 for phase counts 49 to 348, only on a line where `reset_req` was 1 at the arming count 0; on other lines it stays 0.
- R4: On a line where `shift_req` was 1 at count 0, each phase bit is inverted from its resting level inside its own window and nowhere else. Bit 0 (phase 1) is inverted for counts 69..128, bit 1 for 109..168, bit 2 for 49..88 and bit 3 for 149..188. No two phases change in the same cycle.
- R5: `stg_clk` equals `img_clk` in every cycle.
- R6: On a line where `shift_req` was 0 at count 0, `img_clk` and `stg_clk` hold the resting pattern for the whole line.
- R7: `shift_req` and `reset_req` are sampled only when the phase count is 0. Changing them at any other count has no effect on that line.
- R8: All outputs are registered. After a rising clock edge they show the state that belongs to the phase count presented before that edge.
- R9: The resting pattern is bit 0 = 1, bit 1 = 1, bit 2 = 0 and bit 3 = 0 (value 4'b0011).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_cnt | input | 12 | Horizontal phase count of the current line |
| shift_req | input | 1 | Request to shift one line, sampled at count 0 |
| reset_req | input | 1 | Request for a charge-reset strobe, sampled at count 0 |
| img_clk | output | 4 | Image-section phase levels, bit 0 = phase 1 |
| stg_clk | output | 4 | Storage-section phase levels, bit 0 = phase 1 |
| ssc | output | 1 | Sample-and-clamp window |
| cr | output | 1 | Substrate charge-reset strobe |

## Verification
The charge-reset strobe and a line shift can both fall on the same line. The strobe window opens at count 49, which is the same cycle in which the phase-3 shift edge fires. The bench requests both on one line, as well as each alone. It checks in every cycle that `cr`, `ssc` and the phase bits each follow their own window, so that neither request masks or shifts the other. A further line toggles the requests right after the arming count, which shows that only the value sampled at count 0 counts.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

    localparam int CNT_W  = 12;
    localparam int N_PH   = 4;
    localparam int N_SEC  = 2;   // image and storage sections

    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [N_PH-1:0]  phase_t;

    // Resting level of each phase, bit 0 = phase 1
    localparam phase_t IDLE_LVL = 4'b0011;

    // Window used by both the clamp window and the reset strobe
    localparam int SSC_LO = 49;
    localparam int SSC_HI = 349;

    // Compare table: first count of the inverted window for phase k
    function automatic int ph_lo(int k);
        case (k)
            0:       return 69;
            1:       return 109;
            2:       return 49;
            default: return 149;
        endcase
    endfunction

    // Compare table: first count after the inverted window for phase k
    function automatic int ph_hi(int k);
        return ph_lo(k) + ((k == 2 || k == 3) ? 40 : 60);
    endfunction

endpackage

// File: rtl/seq_window.sv
module seq_window #(
    parameter int W  = 12,
    parameter int LO = 0,
    parameter int HI = 1
) (
    input  logic [W-1:0] cnt,
    output logic         hit
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    always_comb hit = (cnt >= LO_V) && (cnt < HI_V);
endmodule

// File: rtl/seq_arm.sv
module seq_arm #(
    parameter int W   = 12,
    parameter int ARM = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cnt,
    input  logic         req,
    output logic         armed
);
    localparam logic [W-1:0] ARM_V = W'(ARM);

    always_ff @(posedge clk) begin
        if (rst)
            armed <= 1'b0;
        else if (cnt == ARM_V)
            armed <= req;
    end
endmodule

// File: rtl/vshift_seq.sv
module vshift_seq
    import vshift_pkg::*;
#(
    parameter int CW      = vshift_pkg::CNT_W,
    parameter int ARM_CNT = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] phase_cnt,
    input  logic          shift_req,
    input  logic          reset_req,
    output logic [3:0]    img_clk,
    output logic [3:0]    stg_clk,
    output logic          ssc,
    output logic          cr
);
    logic   shift_armed;
    logic   cr_armed;
    logic   ssc_hit;
    phase_t ph_hit;
    phase_t next_lvl;
    logic [N_SEC-1:0][N_PH-1:0] sec_q;
    logic   ssc_q;
    logic   cr_q;

    seq_arm #(.W(CW), .ARM(ARM_CNT)) u_arm_shift (
        .clk(clk), .rst(rst), .cnt(phase_cnt), .req(shift_req), .armed(shift_armed)
    );

    seq_arm #(.W(CW), .ARM(ARM_CNT)) u_arm_cr (
        .clk(clk), .rst(rst), .cnt(phase_cnt), .req(reset_req), .armed(cr_armed)
    );

    // One comparator pair per phase, edges from the package table
    for (genvar k = 0; k < N_PH; k++) begin : g_phase
        seq_window #(.W(CW), .LO(ph_lo(k)), .HI(ph_hi(k))) u_win (
            .cnt(phase_cnt), .hit(ph_hit[k])
        );
    end

    seq_window #(.W(CW), .LO(SSC_LO), .HI(SSC_HI)) u_ssc_win (
        .cnt(phase_cnt), .hit(ssc_hit)
    );

    always_comb next_lvl = IDLE_LVL ^ (ph_hit & {N_PH{shift_armed}});

    // Each section has its own output register
    for (genvar s = 0; s < N_SEC; s++) begin : g_sec
        always_ff @(posedge clk) begin
            if (rst) sec_q[s] <= IDLE_LVL;
            else     sec_q[s] <= next_lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ssc_q <= 1'b0;
            cr_q  <= 1'b0;
        end else begin
            ssc_q <= ssc_hit;
            cr_q  <= ssc_hit & cr_armed;
        end
    end

    assign img_clk = sec_q[0];
    assign stg_clk = sec_q[1];
    assign ssc     = ssc_q;
    assign cr      = cr_q;
endmodule

// File: rtl/vshift_seq_chk.sv
module vshift_seq_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst,
    input logic [CW-1:0] phase_cnt,
    input logic [3:0]    img_clk,
    input logic [3:0]    stg_clk,
    input logic          ssc,
    input logic          cr
);
    // R5: both sections carry identical levels
    p_sections_equal_r5: assert property (@(posedge clk) disable iff (rst)
        stg_clk == img_clk);

    // R2: the clamp window opens only after count 49 was presented
    p_ssc_open_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ssc) |-> $past(phase_cnt) == CW'(49));

    // R3: the reset strobe never lies outside the clamp window
    p_cr_inside_r3: assert property (@(posedge clk) disable iff (rst)
        cr |-> ssc);

    // R4: staggered edges, at most one phase moves per cycle
    p_one_edge_r4: assert property (@(posedge clk) disable iff (rst)
        $countones(img_clk ^ $past(img_clk)) <= 1);

    // R9: ahead of every shift window the phases rest
    p_rest_early_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(phase_cnt) < CW'(49)) |=> 1'b1 ##0 (img_clk == 4'b0011 || $past(phase_cnt) >= CW'(49)));
endmodule

bind vshift_seq vshift_seq_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .phase_cnt(phase_cnt),
    .img_clk(img_clk), .stg_clk(stg_clk), .ssc(ssc), .cr(cr)
);

// File: tb/tb_vshift_seq.sv
`timescale 1ns/1ps
module tb_vshift_seq;
    localparam int LINE = 420;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] phase_cnt = '0;
    logic        shift_req = 1'b0;
    logic        reset_req = 1'b0;
    logic [3:0]  img_clk, stg_clk;
    logic        ssc, cr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    vshift_seq dut (
        .clk(clk), .rst(rst), .phase_cnt(phase_cnt),
        .shift_req(shift_req), .reset_req(reset_req),
        .img_clk(img_clk), .stg_clk(stg_clk), .ssc(ssc), .cr(cr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_phase(int c, bit arm);
        logic [3:0] m;
        m[0] = (c >= 69)  && (c < 129);
        m[1] = (c >= 109) && (c < 169);
        m[2] = (c >= 49)  && (c < 89);
        m[3] = (c >= 149) && (c < 189);
        return 4'b0011 ^ (arm ? m : 4'b0000);
    endfunction

    // One full line; sh/rq are driven at count 0, flip inverts them afterwards (R7)
    task automatic run_line(input bit sh, input bit rq, input bit flip, input string tag);
        bit in_w;
        logic [3:0] ep;
        for (int c = 0; c <= LINE; c++) begin
            @(negedge clk);
            if (c > 0) begin
                in_w = (c - 1 >= 49) && (c - 1 < 349);
                ep   = exp_phase(c - 1, sh);
                check(img_clk == ep, {tag, " R4 R6 img_clk"}, img_clk, ep);
                check(stg_clk == ep, {tag, " R5 stg_clk"}, stg_clk, ep);
                check(ssc == in_w, {tag, " R2 ssc"}, ssc, in_w);
                check(cr == (in_w & rq), {tag, " R3 cr"}, cr, in_w & rq);
            end
            if (c < LINE) begin
                phase_cnt = 12'(c);
                shift_req = (c == 0) ? sh : (flip ? ~sh : sh);
                reset_req = (c == 0) ? rq : (flip ? ~rq : rq);
                if (c == 49) begin
                    #1;
                    check(ssc == 1'b0, {tag, " R8 ssc before edge"}, ssc, 0);
                end
            end
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(img_clk == 4'b0011, "R1 img_clk", img_clk, 4'b0011);
        check(stg_clk == 4'b0011, "R1 R9 stg_clk", stg_clk, 4'b0011);
        check(ssc == 1'b0, "R1 ssc", ssc, 0);
        check(cr == 1'b0, "R1 cr", cr, 0);
        rst = 1'b0;
        @(negedge clk);
        check(img_clk == 4'b0011 && !ssc && !cr, "R1 after release", img_clk, 4'b0011);
    endtask

    task automatic t_idle();       run_line(1'b0, 1'b0, 1'b0, "idle");       endtask
    task automatic t_shift();      run_line(1'b1, 1'b0, 1'b0, "shift");      endtask
    task automatic t_shift_again();run_line(1'b1, 1'b0, 1'b0, "shift2");     endtask
    task automatic t_reset_only(); run_line(1'b0, 1'b1, 1'b0, "cr_only");    endtask
    task automatic t_both();       run_line(1'b1, 1'b1, 1'b0, "both");       endtask
    task automatic t_late_on();    run_line(1'b0, 1'b0, 1'b1, "R7 late_on"); endtask
    task automatic t_late_off();   run_line(1'b1, 1'b1, 1'b1, "R7 late_off");endtask

    initial begin
        t_reset();
        t_idle();
        t_shift();
        t_shift_again();
        t_reset_only();
        t_both();
        t_late_on();
        t_late_off();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule